// File: doc/BRIEF.md
# Raster Timing Generator with Frame-Boundary Configuration Commit

This block produces the timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe, a data-gate strobe and the coordinates of the pixel currently in the active window. Software programs the sync widths, the porches, the active size and the sync polarities through a simple write port. These writes land in a shadow copy. The counters only ever use a second, active copy, and the shadow copy moves into it at the end of a frame. A reload-hold bit can block that move, so that a multi-register update can be assembled over several frames and committed as a unit.

Every frame boundary also sets a pending interrupt flag. The flag drives the interrupt line through an enable mask, and software clears it by writing a one to a clear address. The control register starts and stops the raster, gates the data strobe and carries an output pixel format code that is passed to the panel interface unchanged.

A line is a sync interval, then the back porch, then the active pixels, then the front porch. Lines count the same way to make a frame. The generator advances one position per clock, so the clock is the pixel clock.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, de, data_gate, frame_end, irq, hsync, vsync and pix_fmt are all 0, the reload hold is clear, and every active timing field is zero, which gives a 2-by-2 position frame.
- R2: Each line lasts hsync width + back porch + active width + front porch cycles, in that order. Address 3 bits [7:0] holds the hsync width minus 1. Address 1 holds the back porch in bits [23:16] and the front porch in bits [7:0].
- R3: Each frame lasts vsync width + back porch + active height + front porch lines, in that order. Address 4 bits [3:0] holds the vsync width minus 1, so the width is at most 16 lines. Address 2 holds the vertical porches with the same packing as address 1.
- R4: Address 5 holds the height minus 1 in bits [26:16] and the width minus 1 in bits [10:0]. de is high only when both counters are inside the active window. pix_x and pix_y give the offset within that window while de is high and are 0 otherwise.
- R5: Address 6 bit 0 makes hsync active low and bit 1 makes vsync active low. The inactive level is held whenever the raster is stopped.
- R6: frame_end is a single-cycle pulse on the last position of the last front-porch line. On the next cycle both counters are at 0.
- R7: Writes to addresses 1 to 6 reach the outputs only at the clock edge that ends a frame while the raster runs. A write made on that same edge waits for the following frame end.
- R8: While address 9 bit 0 is set, the frame-end edge keeps the old active settings.
- R9: Address 0 bit 0 runs the raster. When it is clear, the counters are held at 0, no strobe is active and no frame end occurs. The raster restarts from position 0 when the bit is set again.
- R10: data_gate equals de AND address 0 bit 1.
- R11: Every frame end sets a pending flag, and irq is that flag AND address 7 bit 0. Writing 1 to address 8 bit 0 clears the flag. If a frame end lands in the same cycle as the clear, the flag stays set.
- R12: pix_fmt follows address 0 bits [6:4] from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity per setting |
| vsync | output | 1 | Vertical sync, polarity per setting |
| de | output | 1 | Active-window data enable |
| data_gate | output | 1 | Gated data enable for the pixel path |
| pix_x | output | 11 | Column inside the active window |
| pix_y | output | 11 | Row inside the active window |
| frame_end | output | 1 | One-cycle end-of-frame pulse |
| irq | output | 1 | Masked frame-end interrupt |
| pix_fmt | output | 3 | Output pixel format code |

## Verification
Two pairs of events can land on the same clock edge. In the first pair, a frame end sets the pending flag while software writes the clear bit. The bench watches its own frame-position model, issues the clear exactly on the frame-end edge, and expects irq to stay high. A clear issued away from a frame end must drop irq. In the second pair, a porch write arrives on the commit edge. The bench expects the old active settings for the frame that follows and the new ones only after the next frame end. Both cases are judged cycle by cycle against raster positions that the bench computes arithmetically from the requirements.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int SZ_W  = 11;
    localparam int PR_W  = 8;
    localparam int HS_W  = 8;
    localparam int VS_W  = 4;
    localparam int FMT_W = 3;
    localparam int AW    = 4;
    localparam int DW    = 32;
    localparam int CW    = SZ_W + 2;
    localparam int HI    = 16;

    localparam logic [AW-1:0] A_CTRL   = 4'd0;
    localparam logic [AW-1:0] A_HPORCH = 4'd1;
    localparam logic [AW-1:0] A_VPORCH = 4'd2;
    localparam logic [AW-1:0] A_HSYNC  = 4'd3;
    localparam logic [AW-1:0] A_VSYNC  = 4'd4;
    localparam logic [AW-1:0] A_SIZE   = 4'd5;
    localparam logic [AW-1:0] A_POL    = 4'd6;
    localparam logic [AW-1:0] A_INT_EN = 4'd7;
    localparam logic [AW-1:0] A_INTCLR = 4'd8;
    localparam logic [AW-1:0] A_HOLD   = 4'd9;

    typedef struct packed {
        logic [PR_W-1:0] hbp;
        logic [PR_W-1:0] hfp;
        logic [PR_W-1:0] vbp;
        logic [PR_W-1:0] vfp;
        logic [HS_W-1:0] hsw_m1;
        logic [VS_W-1:0] vsw_m1;
        logic [SZ_W-1:0] w_m1;
        logic [SZ_W-1:0] h_m1;
        logic            hs_low;
        logic            vs_low;
    } tcfg_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             frame_end,
    output tcfg_t            act_cfg,
    output logic             run_en,
    output logic             gate_en,
    output logic [FMT_W-1:0] fmt,
    output logic             int_en,
    output logic             clr_pulse
);
    typedef struct packed {
        tcfg_t            shd;
        tcfg_t            act;
        logic             en;
        logic             gate;
        logic [FMT_W-1:0] fmt;
        logic             ie;
        logic             hold;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        clr_pulse = 1'b0;
        if (frame_end && !st_q.hold) st_d.act = st_q.shd;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    st_d.en   = wr_data[0];
                    st_d.gate = wr_data[1];
                    st_d.fmt  = wr_data[4 +: FMT_W];
                end
                A_HPORCH: begin
                    st_d.shd.hfp = wr_data[0 +: PR_W];
                    st_d.shd.hbp = wr_data[HI +: PR_W];
                end
                A_VPORCH: begin
                    st_d.shd.vfp = wr_data[0 +: PR_W];
                    st_d.shd.vbp = wr_data[HI +: PR_W];
                end
                A_HSYNC:  st_d.shd.hsw_m1 = wr_data[0 +: HS_W];
                A_VSYNC:  st_d.shd.vsw_m1 = wr_data[0 +: VS_W];
                A_SIZE: begin
                    st_d.shd.w_m1 = wr_data[0 +: SZ_W];
                    st_d.shd.h_m1 = wr_data[HI +: SZ_W];
                end
                A_POL: begin
                    st_d.shd.hs_low = wr_data[0];
                    st_d.shd.vs_low = wr_data[1];
                end
                A_INT_EN: st_d.ie   = wr_data[0];
                A_INTCLR: clr_pulse = wr_data[0];
                A_HOLD:   st_d.hold = wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_cfg = st_q.act;
    assign run_en  = st_q.en;
    assign gate_en = st_q.gate;
    assign fmt     = st_q.fmt;
    assign int_en  = st_q.ie;

    p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !st_q.hold) |=> (st_q.act == $past(st_q.shd)));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_end || st_q.hold) |=> (st_q.act == $past(st_q.act)));
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters
    import dtg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  tcfg_t           cfg,
    output logic            frame_end,
    output logic            hsync,
    output logic            vsync,
    output logic            de,
    output logic [SZ_W-1:0] pix_x,
    output logic [SZ_W-1:0] pix_y
);
    typedef struct packed {
        logic [CW-1:0] h;
        logic [CW-1:0] v;
    } pos_t;

    pos_t pos_d, pos_q;
    logic [CW-1:0] hs_len, h_beg, h_end, h_tot;
    logic [CW-1:0] vs_len, v_beg, v_end, v_tot;
    logic h_last, v_last, h_act, v_act;

    always_comb begin
        hs_len = CW'(cfg.hsw_m1) + 1'b1;
        h_beg  = hs_len + CW'(cfg.hbp);
        h_end  = h_beg + CW'(cfg.w_m1) + 1'b1;
        h_tot  = h_end + CW'(cfg.hfp);
        vs_len = CW'(cfg.vsw_m1) + 1'b1;
        v_beg  = vs_len + CW'(cfg.vbp);
        v_end  = v_beg + CW'(cfg.h_m1) + 1'b1;
        v_tot  = v_end + CW'(cfg.vfp);

        h_last    = (pos_q.h == h_tot - 1'b1);
        v_last    = (pos_q.v == v_tot - 1'b1);
        frame_end = run_en && h_last && v_last;

        pos_d = pos_q;
        if (!run_en) begin
            pos_d = '0;
        end else if (h_last) begin
            pos_d.h = '0;
            pos_d.v = v_last ? '0 : pos_q.v + 1'b1;
        end else begin
            pos_d.h = pos_q.h + 1'b1;
        end

        h_act = (pos_q.h >= h_beg) && (pos_q.h < h_end);
        v_act = (pos_q.v >= v_beg) && (pos_q.v < v_end);
        de    = run_en && h_act && v_act;
        hsync = (run_en && (pos_q.h < hs_len)) ^ cfg.hs_low;
        vsync = (run_en && (pos_q.v < vs_len)) ^ cfg.vs_low;
        pix_x = de ? SZ_W'(pos_q.h - h_beg) : '0;
        pix_y = de ? SZ_W'(pos_q.v - v_beg) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (pos_q.h == '0 && pos_q.v == '0));
    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);
    p_hrange_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> (pos_q.h < h_tot));
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (pos_q.h == '0 && pos_q.v == '0));
endmodule

// File: rtl/dtg_irq.sv
module dtg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic int_en,
    output logic irq
);
    typedef struct packed {
        logic pend;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d.pend = set_evt || (st_q.pend && !clr_evt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.pend && int_en;

    p_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> st_q.pend);
    p_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !st_q.pend);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             data_gate,
    output logic [SZ_W-1:0]  pix_x,
    output logic [SZ_W-1:0]  pix_y,
    output logic             frame_end,
    output logic             irq,
    output logic [FMT_W-1:0] pix_fmt
);
    tcfg_t act_cfg;
    logic  run_en, gate_en, int_en, clr_pulse;

    dtg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_end(frame_end), .act_cfg(act_cfg),
        .run_en(run_en), .gate_en(gate_en), .fmt(pix_fmt),
        .int_en(int_en), .clr_pulse(clr_pulse)
    );

    dtg_counters u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg(act_cfg),
        .frame_end(frame_end), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .pix_y(pix_y)
    );

    dtg_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set_evt(frame_end), .clr_evt(clr_pulse),
        .int_en(int_en), .irq(irq)
    );

    assign data_gate = de && gate_en;

    p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        data_gate |-> de);
    p_fe_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && int_en && !(wr_en && wr_addr == A_INT_EN)) |=> irq);
endmodule

// File: tb/sim_disp_timing_gen.sv
module sim_disp_timing_gen;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, de, data_gate, frame_end, irq;
    logic [10:0] pix_x, pix_y;
    logic [2:0]  pix_fmt;

    int errors = 0;
    int checks = 0;

    // bench model: shadow (s_) and active (e_) fields, control, counters
    int s_hfp, s_hbp, s_vfp, s_vbp, s_hsw, s_vsw, s_w, s_h, s_hl, s_vl;
    int e_hfp, e_hbp, e_vfp, e_vbp, e_hsw, e_vsw, e_w, e_h, e_hl, e_vl;
    int m_en, m_gate, m_fmt, m_ie, m_hold, m_pend, hc, vc;

    always #(PERIOD/2) clk = ~clk;

    disp_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
        .data_gate(data_gate), .pix_x(pix_x), .pix_y(pix_y),
        .frame_end(frame_end), .irq(irq), .pix_fmt(pix_fmt)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (h=%0d v=%0d)", req, got, exp, hc, vc);
        end
    endtask

    function automatic int htot();
        return e_hsw + 1 + e_hbp + e_w + 1 + e_hfp;
    endfunction
    function automatic int vtot();
        return e_vsw + 1 + e_vbp + e_h + 1 + e_vfp;
    endfunction
    function automatic int fe_now();
        return (m_en != 0 && hc == htot() - 1 && vc == vtot() - 1) ? 1 : 0;
    endfunction

    // called at a falling edge: check outputs, then drive inputs for the next edge
    task automatic tick(input int we, input int a, input int d);
        int hb, vb, act, clr;
        hb  = e_hsw + 1 + e_hbp;
        vb  = e_vsw + 1 + e_vbp;
        act = (m_en != 0 && hc >= hb && hc < hb + e_w + 1 && vc >= vb && vc < vb + e_h + 1) ? 1 : 0;
        chk("R2/R5 hsync", int'(hsync), ((m_en != 0 && hc < e_hsw + 1) ? 1 : 0) ^ e_hl);
        chk("R3/R5 vsync", int'(vsync), ((m_en != 0 && vc < e_vsw + 1) ? 1 : 0) ^ e_vl);
        chk("R4 de", int'(de), act);
        chk("R4 pix_x", int'(pix_x), act != 0 ? hc - hb : 0);
        chk("R4 pix_y", int'(pix_y), act != 0 ? vc - vb : 0);
        chk("R6 frame_end", int'(frame_end), fe_now());
        chk("R10 data_gate", int'(data_gate), act & m_gate);
        chk("R11 irq", int'(irq), m_pend & m_ie);
        chk("R12 pix_fmt", int'(pix_fmt), m_fmt);
        wr_en   = (we != 0);
        wr_addr = 4'(a);
        wr_data = d;
        clr = (we != 0 && a == 8 && d[0]) ? 1 : 0;
        m_pend = (fe_now() != 0 || (m_pend != 0 && clr == 0)) ? 1 : 0;
        if (m_en == 0) begin
            hc = 0; vc = 0;
        end else if (fe_now() != 0) begin
            hc = 0; vc = 0;
            if (m_hold == 0) begin
                e_hfp = s_hfp; e_hbp = s_hbp; e_vfp = s_vfp; e_vbp = s_vbp;
                e_hsw = s_hsw; e_vsw = s_vsw; e_w = s_w; e_h = s_h;
                e_hl = s_hl; e_vl = s_vl;
            end
        end else if (hc == htot() - 1) begin
            hc = 0; vc++;
        end else begin
            hc++;
        end
        if (we != 0) begin
            case (a)
                0: begin m_en = d & 1; m_gate = (d >> 1) & 1; m_fmt = (d >> 4) & 7; end
                1: begin s_hfp = d & 255; s_hbp = (d >> 16) & 255; end
                2: begin s_vfp = d & 255; s_vbp = (d >> 16) & 255; end
                3: s_hsw = d & 255;
                4: s_vsw = d & 15;
                5: begin s_w = d & 2047; s_h = (d >> 16) & 2047; end
                6: begin s_hl = d & 1; s_vl = (d >> 1) & 1; end
                7: m_ie = d & 1;
                9: m_hold = d & 1;
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0);
    endtask

    task automatic frames(input int n);
        int seen;
        seen = 0;
        while (seen < n) begin
            if (fe_now() != 0) seen++;
            tick(0, 0, 0);
        end
    endtask

    task automatic to_frame_end();
        while (fe_now() == 0) tick(0, 0, 0);
    endtask

    task automatic setup(input int hsw, input int hbp, input int hfp, input int w,
                         input int vsw, input int vbp, input int vfp, input int h);
        tick(1, 3, hsw);
        tick(1, 1, (hbp << 16) | hfp);
        tick(1, 4, vsw);
        tick(1, 2, (vbp << 16) | vfp);
        tick(1, 5, (h << 16) | w);
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        {s_hfp, s_hbp, s_vfp, s_vbp, s_hsw, s_vsw, s_w, s_h, s_hl, s_vl} = '0;
        {e_hfp, e_hbp, e_vfp, e_vbp, e_hsw, e_vsw, e_w, e_h, e_hl, e_vl} = '0;
        {m_en, m_gate, m_fmt, m_ie, m_hold, m_pend, hc, vc} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle state after reset
        chk("R1 de", int'(de), 0);
        chk("R1 hsync", int'(hsync), 0);
        chk("R1 frame_end", int'(frame_end), 0);
        chk("R1 irq", int'(irq), 0);
        idle(4);

        // R9 / R7: run on default 2x2 frame, then commit a first setting
        setup(1, 2, 1, 3, 0, 1, 1, 2);
        tick(1, 0, 32'h53);          // run, gate, fmt 5 (R12)
        frames(3);

        // R11: irq masked then enabled, collision with clear, plain clear
        tick(1, 7, 1);
        idle(1);
        to_frame_end();
        tick(1, 8, 1);               // R11 clear on frame-end edge: flag survives
        idle(3);
        tick(1, 8, 1);               // R11 plain clear
        idle(2);

        // R5: both polarities inverted
        tick(1, 6, 3);
        frames(2);

        // R7: write landing on the commit edge waits one frame
        to_frame_end();
        tick(1, 1, (0 << 16) | 2);
        frames(2);

        // R8: hold blocks commit, release lets it through
        tick(1, 9, 1);
        setup(0, 0, 0, 1, 1, 0, 2, 0);
        frames(2);
        tick(1, 9, 0);
        frames(2);

        // R9: stop mid-frame, then restart from zero
        idle(5);
        tick(1, 0, 0);
        idle(4);
        tick(1, 0, 32'h21);          // run, gate off (R10), fmt 2
        frames(2);

        // R2/R3/R4: sweep of small timing sets
        tick(1, 6, 0);
        for (int hs = 0; hs < 2; hs++)
            for (int hb = 0; hb < 2; hb++)
                for (int hf = 0; hf < 2; hf++)
                    for (int w = 0; w < 3; w++) begin
                        setup(hs, hb, hf, w, (hb + w) % 2, hf, (hs + w) % 3, w % 2);
                        frames(2);
                    end
        tick(1, 0, 32'h03);
        frames(1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule